// File: doc/BRIEF.md
# USB Device Status and Interrupt Controller

This block collects bus events for a full-speed USB device function and turns them into sticky status flags, a mask register and one CPU interrupt request. A simple protocol front end supplies single-cycle strobes: start-of-frame seen, SETUP received, bus reset, resume signalling and a configuration-value write. It also supplies a level that is high while the bus sits in the idle (J) state. The block counts idle time itself. After three milliseconds of unbroken idle it raises the suspend flag.

The CPU reaches the block through a byte-wide port with one address bit. Address 0 selects the status register and address 1 selects the mask register. The mask register also carries a forced-STALL control for endpoint 0. The CPU can only set this control; it stays set until the next SETUP arrives. While it is set, `ep0_stall_o` tells the handshake generator to answer IN and OUT tokens on endpoint 0 with STALL.

Two state machines carry the sequencing.

The idle timer has three states and six transitions:
- `IDLE_ACTIVE` goes to `IDLE_COUNT` when the bus goes idle, and otherwise stays in `IDLE_ACTIVE`.
- `IDLE_COUNT` goes back to `IDLE_ACTIVE` on any activity.
- `IDLE_COUNT` goes to `IDLE_SUSP` when the count reaches three milliseconds.
- `IDLE_SUSP` stays while the bus is idle and returns to `IDLE_ACTIVE` on activity.

The STALL controller has two states:
- `STALL_OFF` goes to `STALL_ON` when the CPU writes a 1 to the STALL bit.
- `STALL_ON` goes to `STALL_OFF` when a SETUP arrives without a STALL write in the same cycle.

Top module: `usb_dev_irq_ctrl`

## Requirements
- R1: After reset, all status flags, all mask bits, `irq_o` and `ep0_stall_o` are 0, and both registers read 0x00.
- R2: Each event strobe sets its status flag whether or not the matching mask bit is set. The status bits are: bit 5 SETUP, bit 4 SOF, bit 3 configuration change, bit 2 bus reset, bit 1 resume, bit 0 suspend. Bits 7 and 6 read 0. A set flag stays set until the CPU clears it.
- R3: A CPU write to address 0 clears each flag whose write-data bit is 0 and leaves each flag whose bit is 1 unchanged. When an event strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: A configuration write sets the configuration-change flag only when the previously written value was zero and the new value is nonzero. The previous value is 0 after reset.
- R5: The suspend flag is set one clock after the (IDLE_MS×CLK_PER_MS+1)-th consecutive clock edge at which `bus_idle_i` is high. Any cycle with `bus_idle_i` low restarts the count. The flag is raised at most once per unbroken idle run, so a flag cleared during that run stays clear.
- R6: `irq_o` is registered. In each cycle it equals the OR, over all six bits, of flag AND mask as they stood in the previous cycle.
- R7: A write to address 1 loads mask bits 5..0 into the positions listed in R2. A read of address 1 returns those six bits, with bits 7 and 6 read as 0.
- R8: Writing address 1 with bit 6 set raises `ep0_stall_o` in the next cycle. A write with bit 6 clear has no effect on it. A SETUP strobe clears it in the next cycle.
- R9: When a STALL-setting write and a SETUP strobe occur in the same cycle, `ep0_stall_o` is 1 afterwards.
- R10: `cpu_rdata_o` reads 0x00 whenever `cpu_sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle_i | input | 1 | High while the bus is in the idle state |
| sof_i | input | 1 | Start-of-frame strobe |
| setup_i | input | 1 | SETUP-received strobe |
| bus_reset_i | input | 1 | Bus-reset strobe |
| resume_i | input | 1 | Resume-signalling strobe |
| cfg_wr_i | input | 1 | Configuration-value write strobe |
| cfg_val_i | input | 8 | Configuration value being written |
| cpu_sel_i | input | 1 | CPU port select |
| cpu_wr_i | input | 1 | CPU write enable (with select) |
| cpu_addr_i | input | 1 | 0 = status register, 1 = mask register |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data |
| irq_o | output | 1 | CPU interrupt request |
| ep0_stall_o | output | 1 | Endpoint 0 forced-STALL request |

## Verification
Two pairs of functions can act on the same bit in the same cycle:
- an event strobe and a CPU write that clears the same status flag;
- a SETUP strobe and a CPU write that sets endpoint-0 STALL.

The bench provokes each pair with directed cycles and then with a long pseudo-random stretch in which strobes and writes overlap freely. A behavioural model gives every set request priority and is compared with the outputs at each clock. The suspend path gets idle runs that stop one edge short of the limit, that just reach it, and that are cleared while the bus is still idle.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int NFLAG     = 6;
    localparam int F_SUSP    = 0;
    localparam int F_RESUME  = 1;
    localparam int F_BRST    = 2;
    localparam int F_CFG     = 3;
    localparam int F_SOF     = 4;
    localparam int F_SETUP   = 5;
    localparam int STALL_BIT = 6;

    typedef enum logic [1:0] {
        IDLE_ACTIVE = 2'd0,
        IDLE_COUNT  = 2'd1,
        IDLE_SUSP   = 2'd2
    } idle_state_e;

    typedef enum logic {
        STALL_OFF = 1'b0,
        STALL_ON  = 1'b1
    } stall_state_e;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer
    import usb_irq_pkg::*;
#(
    parameter int CLK_PER_MS = 125000,
    parameter int IDLE_MS    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle_i,
    output logic susp_set_o
);
    localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam int MS_W  = $clog2(IDLE_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(IDLE_MS - 1);

    idle_state_e state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             term;

    assign term = (pre_q == PRE_LAST) && (ms_q == MS_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_ACTIVE: state_d = bus_idle_i ? IDLE_COUNT : IDLE_ACTIVE;
            IDLE_COUNT: begin
                if (!bus_idle_i) state_d = IDLE_ACTIVE;
                else if (term)   state_d = IDLE_SUSP;
                else             state_d = IDLE_COUNT;
            end
            IDLE_SUSP:   state_d = bus_idle_i ? IDLE_SUSP : IDLE_ACTIVE;
            default:     state_d = IDLE_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if ((state_q != IDLE_COUNT) || !bus_idle_i) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            ms_q  <= ms_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        susp_set_o = (state_q == IDLE_COUNT) && bus_idle_i && term;
    end

    // R5
    activity_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle_i |=> (state_q == IDLE_ACTIVE));
    // R5
    suspend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_set_o |=> (state_q == IDLE_SUSP) && !susp_set_o);
endmodule

// File: rtl/usb_status_flags.sv
module usb_status_flags
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_i,
    input  logic             sof_i,
    input  logic             bus_reset_i,
    input  logic             resume_i,
    input  logic             susp_set_i,
    input  logic             cfg_wr_i,
    input  logic [7:0]       cfg_val_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] keep_i,
    output logic [NFLAG-1:0] flags_o
);
    logic [7:0]       cfg_prev_q;
    logic             cfg_rise;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_prev_q <= '0;
        else if (cfg_wr_i) cfg_prev_q <= cfg_val_i;
    end

    assign cfg_rise = cfg_wr_i && (cfg_prev_q == '0) && (cfg_val_i != '0);

    always_comb begin
        set_vec          = '0;
        set_vec[F_SUSP]  = susp_set_i;
        set_vec[F_RESUME]= resume_i;
        set_vec[F_BRST]  = bus_reset_i;
        set_vec[F_CFG]   = cfg_rise;
        set_vec[F_SOF]   = sof_i;
        set_vec[F_SETUP] = setup_i;
        clr_vec          = clr_wr_i ? ~keep_i : '0;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags_o[i] <= 1'b0;
            else if (set_vec[i]) flags_o[i] <= 1'b1;
            else if (clr_vec[i]) flags_o[i] <= 1'b0;
        end
    end

    // R2
    setup_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_i |=> flags_o[F_SETUP]);
    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[F_SOF] && !(clr_wr_i && !keep_i[F_SOF])) |=> flags_o[F_SOF]);
    // R4
    cfg_zero_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[F_CFG] && !(cfg_wr_i && cfg_val_i != 8'h00)) |=> !flags_o[F_CFG]);
endmodule

// File: rtl/usb_ep0_stall.sv
module usb_ep0_stall
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req_i,
    input  logic setup_i,
    output logic stall_o
);
    stall_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STALL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STALL_OFF: state_d = set_req_i ? STALL_ON : STALL_OFF;
            STALL_ON:  state_d = (setup_i && !set_req_i) ? STALL_OFF : STALL_ON;
            default:   state_d = STALL_OFF;
        endcase
    end

    always_comb begin
        stall_o = (state_q == STALL_ON);
    end

    // R8
    setup_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_i && !set_req_i) |=> !stall_o);
    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req_i |=> stall_o);
endmodule

// File: rtl/usb_dev_irq_ctrl.sv
module usb_dev_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter int CLK_PER_MS = 125000,
    parameter int IDLE_MS    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_idle_i,
    input  logic       sof_i,
    input  logic       setup_i,
    input  logic       bus_reset_i,
    input  logic       resume_i,
    input  logic       cfg_wr_i,
    input  logic [7:0] cfg_val_i,
    input  logic       cpu_sel_i,
    input  logic       cpu_wr_i,
    input  logic       cpu_addr_i,
    input  logic [7:0] cpu_wdata_i,
    output logic [7:0] cpu_rdata_o,
    output logic       irq_o,
    output logic       ep0_stall_o
);
    logic             wr_stat, wr_mask, susp_set, stall_req;
    logic [NFLAG-1:0] flags, mask_q;
    logic             unused_wdata;

    assign wr_stat      = cpu_sel_i && cpu_wr_i && !cpu_addr_i;
    assign wr_mask      = cpu_sel_i && cpu_wr_i &&  cpu_addr_i;
    assign stall_req    = wr_mask && cpu_wdata_i[STALL_BIT];
    assign unused_wdata = cpu_wdata_i[7];

    usb_idle_timer #(.CLK_PER_MS(CLK_PER_MS), .IDLE_MS(IDLE_MS)) u_idle (
        .clk(clk), .rst_n(rst_n), .bus_idle_i(bus_idle_i), .susp_set_o(susp_set)
    );

    usb_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .setup_i(setup_i), .sof_i(sof_i),
        .bus_reset_i(bus_reset_i), .resume_i(resume_i), .susp_set_i(susp_set),
        .cfg_wr_i(cfg_wr_i), .cfg_val_i(cfg_val_i), .clr_wr_i(wr_stat),
        .keep_i(cpu_wdata_i[NFLAG-1:0]), .flags_o(flags)
    );

    usb_ep0_stall u_stall (
        .clk(clk), .rst_n(rst_n), .set_req_i(stall_req), .setup_i(setup_i),
        .stall_o(ep0_stall_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= cpu_wdata_i[NFLAG-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(flags & mask_q);
    end

    always_comb begin
        cpu_rdata_o = 8'h00;
        if (cpu_sel_i) begin
            cpu_rdata_o[NFLAG-1:0] = cpu_addr_i ? mask_q : flags;
        end
    end

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask_q) == '0) |=> !irq_o);
    // R7
    always_comb begin
        reserved_zero_chk: assert (cpu_rdata_o[7:6] == 2'b00);
    end
endmodule

// File: tb/usb_dev_irq_ctrl_tb.sv
module usb_dev_irq_ctrl_tb;
    localparam int CPM  = 4;
    localparam int IMS  = 3;
    localparam int NIDL = CPM * IMS;

    logic clk = 0, rst_n = 0;
    logic bus_idle = 0, sof = 0, setup = 0, brst = 0, resume = 0, cfg_wr = 0;
    logic [7:0] cfg_val = 0, wdata = 0, rdata;
    logic sel = 1, wr = 0, addr = 0, irq, stall;

    always #4 clk = ~clk;

    usb_dev_irq_ctrl #(.CLK_PER_MS(CPM), .IDLE_MS(IMS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_idle_i(bus_idle), .sof_i(sof),
        .setup_i(setup), .bus_reset_i(brst), .resume_i(resume),
        .cfg_wr_i(cfg_wr), .cfg_val_i(cfg_val), .cpu_sel_i(sel),
        .cpu_wr_i(wr), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
        .cpu_rdata_o(rdata), .irq_o(irq), .ep0_stall_o(stall)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    logic [5:0] m_flags = 0, m_mask = 0;
    logic [7:0] m_prev = 0;
    logic       m_irq = 0, m_stall = 0;
    int         m_run = 0;

    task automatic model_step();
        logic [5:0] setv, clrv;
        if (!rst_n) begin
            m_flags = 0; m_mask = 0; m_prev = 0; m_irq = 0; m_stall = 0; m_run = 0;
            return;
        end
        m_irq = |(m_flags & m_mask);
        m_run = bus_idle ? m_run + 1 : 0;
        setv = {setup, sof, cfg_wr && m_prev == 0 && cfg_val != 0, brst, resume,
                bus_idle && m_run == NIDL + 1};
        clrv = (sel && wr && !addr) ? ~wdata[5:0] : 6'h00;
        m_flags = (m_flags & ~clrv) | setv;
        if (cfg_wr) m_prev = cfg_val;
        if (sel && wr && addr && wdata[6]) m_stall = 1;
        else if (setup) m_stall = 0;
        if (sel && wr && addr) m_mask = wdata[5:0];
    endtask

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        logic [7:0] exp_rd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        exp_rd = !sel ? 8'h00 : (addr ? {2'b00, m_mask} : {2'b00, m_flags});
        check("rdata", rdata, exp_rd);
        check("irq R6", {7'd0, irq}, {7'd0, m_irq});
        check("stall R8", {7'd0, stall}, {7'd0, m_stall});
    endtask

    task automatic cpu_write(logic a, logic [7:0] d);
        addr = a; wdata = d; wr = 1; cyc(); wr = 0;
    endtask

    task automatic pulse(ref logic s);
        s = 1; cyc(); s = 0; cyc();
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        tag = "R1";
        repeat (3) cyc();
        addr = 1; cyc(); addr = 0;
        rst_n = 1; cyc();

        tag = "R2";
        pulse(setup); pulse(sof); pulse(brst); pulse(resume);
        cfg_val = 8'h05; cfg_wr = 1; cyc(); cfg_wr = 0; cyc();
        addr = 1; cyc(); addr = 0; cyc();

        tag = "R3";
        cpu_write(0, 8'h3F); cyc();
        setup = 1; addr = 0; wdata = 8'h00; wr = 1; cyc(); setup = 0; wr = 0; cyc();
        cpu_write(0, 8'h10); cyc();
        cpu_write(0, 8'h00); cyc();

        tag = "R4";
        cfg_val = 8'h07; cfg_wr = 1; cyc(); cfg_wr = 0; cyc();
        cfg_val = 8'h00; cfg_wr = 1; cyc(); cfg_val = 8'h00; cyc(); cfg_wr = 0; cyc();
        cfg_val = 8'h03; cfg_wr = 1; cyc(); cfg_wr = 0; cyc();
        cpu_write(0, 8'h00);

        tag = "R6";
        cpu_write(1, 8'h10); addr = 0; cyc();
        pulse(sof); cyc(); cyc();
        cpu_write(1, 8'h00); cyc(); cyc();
        cpu_write(1, 8'h3F); cyc();
        cpu_write(0, 8'h00); cyc(); cyc();

        tag = "R7";
        cpu_write(1, 8'hFF); cyc();
        cpu_write(1, 8'h15); cyc();

        tag = "R8";
        cpu_write(1, 8'h40); cyc();
        cpu_write(1, 8'h00); cyc();
        pulse(setup); cyc();
        cpu_write(0, 8'h00);

        tag = "R9";
        cpu_write(1, 8'h40); cyc();
        setup = 1; addr = 1; wdata = 8'h40; wr = 1; cyc(); setup = 0; wr = 0; cyc();
        pulse(setup);

        tag = "R5";
        cpu_write(1, 8'h01); addr = 0;
        bus_idle = 1; repeat (NIDL) cyc(); bus_idle = 0; cyc(); cyc();
        bus_idle = 1; repeat (NIDL + 4) cyc();
        cpu_write(0, 8'h00); repeat (NIDL + 4) cyc();
        bus_idle = 0; cyc();
        bus_idle = 1; repeat (5) cyc(); bus_idle = 0; cyc();
        bus_idle = 1; repeat (NIDL + 2) cyc(); bus_idle = 0; cyc();

        tag = "R10";
        sel = 0; cyc(); addr = 1; cyc(); sel = 1; cyc();

        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_idle = (lfsr[3:0] != 4'h0) || lfsr[15];
            sof      = (lfsr[7:5] == 3'b111);
            setup    = (lfsr[9:7] == 3'b101);
            brst     = (lfsr[11:8] == 4'hA);
            resume   = (lfsr[12:9] == 4'h3);
            cfg_wr   = (lfsr[6:4] == 3'b010);
            cfg_val  = lfsr[2] ? 8'h00 : lfsr[15:8];
            addr     = lfsr[10];
            wr       = (lfsr[14:12] == 3'b110);
            wdata    = {lfsr[0], lfsr[11:5]};
            sel      = (lfsr[13:11] != 3'b000);
            cyc();
        end
        wr = 0; sof = 0; setup = 0; brst = 0; resume = 0; cfg_wr = 0;
        cyc();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired during %s", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule